// File: doc/BRIEF.md
# DMA Channel Control Register

This block holds the 8-bit control register of one DMA channel and the logic that the register drives directly. It produces the channel-enable signal, the activation-source code, the block-area role flag, and a destination address that steps after each completed transfer. A CPU reaches the register through a byte-wide interface with separate read and write strobes. Reads return all eight bits combinationally.

The run bit, bit 7, needs a two-step sequence before it can be set. Software must first read the register while the bit is 0, and only then can it write 1. An NMI pulse clears the run bit at once. This suspends the channel until software repeats the two-step sequence. A second control register supplies a companion enable bit, and the channel runs only when both bits are 1. Standby clears the register just as reset does.

The destination address has a load port for its start value. It then moves by `STEP` after each transfer strobe that arrives while the channel is enabled. It moves up, moves down, or stays fixed, depending on bits 5 and 4.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Asynchronous reset and a synchronous high level on `standby_i` both clear the register to 0x00. While standby is high, writes are ignored.
- R2: Writes to bits 6..0 always take effect. Bit 6 is a plain read/write bit. `reg_rdata_o` always shows all eight bits.
- R3: `chan_en_o` is 1 exactly when bit 7 is 1 and `peer_en_i` is 1.
- R4: A write with data bit 7 = 1 sets bit 7 only if it follows a qualifying read. A qualifying read is a `reg_rd_i` strobe made while bit 7 was 0. Without such a read, the write leaves bit 7 as it was.
- R5: Any register write, and any NMI pulse, cancels a pending read qualification.
- R6: A write with data bit 7 = 0 clears bit 7. No read is needed first.
- R7: An NMI pulse clears bit 7 on the next edge and leaves bits 6..0 unchanged. An NMI in the same cycle as a write beats the write's bit 7. The write's bits 6..0 still land.
- R8: When bit 4 = 0, the destination address stays fixed on transfer strobes.
- R9: When bit 4 = 1, each enabled transfer strobe moves the address by `STEP`. Bit 5 = 0 adds `STEP` and bit 5 = 1 subtracts it.
- R10: The destination address does not change on a transfer strobe while `chan_en_o` is 0.
- R11: `act_src_o` equals bits 2..0. `blk_is_dst_o` equals bit 3, where 1 means the block area is the destination.
- R12: `dst_ld_i` loads `dst_ld_addr_i` into the address and takes priority over a transfer step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby level; clears the register |
| reg_rd_i | input | 1 | CPU read strobe |
| reg_wr_i | input | 1 | CPU write strobe |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | Current register value |
| peer_en_i | input | 1 | Companion enable bit from the second control register |
| nmi_i | input | 1 | NMI event pulse |
| xfer_done_i | input | 1 | One pulse per completed transfer |
| dst_ld_i | input | 1 | Load strobe for the destination address |
| dst_ld_addr_i | input | AW | Start value for the destination address |
| chan_en_o | output | 1 | Combined channel enable |
| act_src_o | output | 3 | Activation-source code |
| blk_is_dst_o | output | 1 | Block-area role (1 = destination) |
| dst_addr_o | output | AW | Destination address |

## Verification
The run bit is driven with four write patterns:
- a write of 1 with no read before it;
- a read followed by a write of 1;
- a read cancelled by a write or by an NMI before the write of 1;
- a write that lands in the same cycle as an NMI.

These patterns separate real two-step gating from plain write-through, and from gating that forgets to cancel the read. The address logic is stepped three ways:
- with stepping off;
- with stepping on, counting up;
- with stepping on, counting down.

It is stepped again with the channel disabled by the NMI and by the companion bit, and with a load in the same cycle as a strobe. This exposes a wrong direction, a wrong step size, and stepping while disabled.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  typedef struct packed {
    logic       run;
    logic       rsv;
    logic       dec;
    logic       step_en;
    logic       blk_dst;
    logic [2:0] src;
  } ctrl_reg_t;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       standby_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       nmi_i,
  output ctrl_reg_t  reg_o
);
  ctrl_reg_t r_q, r_d;
  logic      armed_q, armed_d;

  always_comb begin
    r_d     = r_q;
    armed_d = armed_q;
    if (rd_i && !r_q.run) armed_d = 1'b1;
    if (wr_i || nmi_i)    armed_d = 1'b0;
    if (wr_i) begin
      r_d     = ctrl_reg_t'(wdata_i);
      // set only after qualifying read, or keep if already running
      r_d.run = wdata_i[7] & (armed_q | r_q.run);
    end
    if (nmi_i) r_d.run = 1'b0;
    if (standby_i) begin
      r_d     = '0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= '0;
      armed_q <= 1'b0;
    end else begin
      r_q     <= r_d;
      armed_q <= armed_d;
    end
  end

  assign reg_o = r_q;
endmodule

// File: rtl/dma_dst_addr.sv
module dma_dst_addr #(
  parameter int AW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          step_i,
  input  logic          step_en_i,
  input  logic          dec_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] StepV = AW'(STEP);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   addr_q <= '0;
    else if (ld_i)                 addr_q <= ld_addr_i;
    else if (step_i && step_en_i)  addr_q <= dec_i ? addr_q - StepV : addr_q + StepV;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_ctrl_pkg::*;
#(
  parameter int AW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic          reg_rd_i,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          peer_en_i,
  input  logic          nmi_i,
  input  logic          xfer_done_i,
  input  logic          dst_ld_i,
  input  logic [AW-1:0] dst_ld_addr_i,
  output logic          chan_en_o,
  output logic [2:0]    act_src_o,
  output logic          blk_is_dst_o,
  output logic [AW-1:0] dst_addr_o
);
  ctrl_reg_t ctl;

  dma_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .rd_i      (reg_rd_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .nmi_i     (nmi_i),
    .reg_o     (ctl)
  );

  assign chan_en_o    = ctl.run & peer_en_i;
  assign reg_rdata_o  = ctl;
  assign act_src_o    = ctl.src;
  assign blk_is_dst_o = ctl.blk_dst;

  dma_dst_addr #(.AW(AW), .STEP(STEP)) u_dst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (dst_ld_i),
    .ld_addr_i (dst_ld_addr_i),
    .step_i    (xfer_done_i & chan_en_o),
    .step_en_i (ctl.step_en),
    .dec_i     (ctl.dec),
    .addr_o    (dst_addr_o)
  );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int AW   = 16,
  parameter int STEP = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          standby_i,
  input logic          reg_wr_i,
  input logic [7:0]    reg_rdata_o,
  input logic          peer_en_i,
  input logic          nmi_i,
  input logic          xfer_done_i,
  input logic          dst_ld_i,
  input logic          chan_en_o,
  input logic [AW-1:0] dst_addr_o
);
  // R1
  standby_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> reg_rdata_o == 8'h00);
  // R3
  en_needs_peer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_o |-> peer_en_i);
  // R4
  run_rise_by_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[7]) |-> $past(reg_wr_i));
  // R7
  nmi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !reg_rdata_o[7]);
  // R7
  nmi_keeps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !reg_wr_i && !standby_i) |=> reg_rdata_o[6:0] == $past(reg_rdata_o[6:0]));
  // R10
  idle_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_en_o && !dst_ld_i) |=> $stable(dst_addr_o));
  // R9
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && chan_en_o && reg_rdata_o[4] && !reg_rdata_o[5] && !dst_ld_i)
      |=> dst_addr_o == $past(dst_addr_o) + AW'(STEP));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .standby_i   (standby_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .peer_en_i   (peer_en_i),
  .nmi_i       (nmi_i),
  .xfer_done_i (xfer_done_i),
  .dst_ld_i    (dst_ld_i),
  .chan_en_o   (chan_en_o),
  .dst_addr_o  (dst_addr_o)
);

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int STEP  = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          standby = 0, rd = 0, wr = 0, peer = 0, nmi = 0, xfer = 0, ld = 0;
  logic [7:0]    wdata = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    rdata;
  logic          chan_en, blk_dst;
  logic [2:0]    src;
  logic [AW-1:0] daddr;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl #(.AW(AW), .STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .peer_en_i(peer), .nmi_i(nmi),
    .xfer_done_i(xfer), .dst_ld_i(ld), .dst_ld_addr_i(ld_addr), .chan_en_o(chan_en),
    .act_src_o(src), .blk_is_dst_o(blk_dst), .dst_addr_o(daddr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] v);
    @(negedge clk); wr = 1; wdata = v;
    @(negedge clk); wr = 0;
  endtask

  task automatic do_rd();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer = 1;
      @(negedge clk); xfer = 0;
    end
  endtask

  task automatic load(logic [AW-1:0] a);
    @(negedge clk); ld = 1; ld_addr = a;
    @(negedge clk); ld = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset chan_en", chan_en, 0);
    chk("R11 reset src", src, 0);
  endtask

  task automatic t_fields();
    do_wr(8'h7B);
    chk("R2 bits 6..0 written", rdata, 8'h7B);
    chk("R11 act_src", src, 3);
    chk("R11 blk_is_dst", blk_dst, 1);
    do_wr(8'h44);
    chk("R2 reserved bit rw", rdata, 8'h44);
    chk("R11 blk_is_dst low", blk_dst, 0);
  endtask

  task automatic t_arm();
    do_wr(8'hC4);
    chk("R4 set without read ignored", rdata, 8'h44);
    do_rd();
    do_wr(8'hC4);
    chk("R4 set after read", rdata, 8'hC4);
    peer = 0; #1;
    chk("R3 peer low", chan_en, 0);
    peer = 1; #1;
    chk("R3 both high", chan_en, 1);
    do_wr(8'h44);
    chk("R6 write 0 clears run", rdata, 8'h44);
    chk("R3 run low", chan_en, 0);
  endtask

  task automatic t_cancel();
    do_rd();
    do_wr(8'h01);
    do_wr(8'h81);
    chk("R5 write cancels read", rdata, 8'h01);
    do_rd();
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    do_wr(8'h81);
    chk("R5 nmi cancels read", rdata, 8'h01);
  endtask

  task automatic t_nmi();
    do_rd();
    @(negedge clk); wr = 1; wdata = 8'h85; nmi = 1;
    @(negedge clk); wr = 0; nmi = 0;
    chk("R7 nmi beats write", rdata, 8'h05);
    do_rd(); do_wr(8'hA6);
    chk("R7 setup run", rdata, 8'hA6);
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    chk("R7 nmi clears run only", rdata, 8'h26);
  endtask

  task automatic t_dst();
    peer = 1;
    load(16'h0100);
    chk("R12 load", daddr, 16'h0100);
    do_rd(); do_wr(8'h80);
    pulses(3);
    chk("R8 fixed", daddr, 16'h0100);
    do_wr(8'h90);
    pulses(3);
    chk("R9 increment", daddr, 16'h0100 + 3*STEP);
    do_wr(8'hB0);
    pulses(2);
    chk("R9 decrement", daddr, 16'h0100 + STEP);
    peer = 0;
    pulses(2);
    chk("R10 peer off no step", daddr, 16'h0100 + STEP);
    peer = 1;
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    pulses(2);
    chk("R10 nmi suspends", daddr, 16'h0100 + STEP);
    do_rd(); do_wr(8'h90);
    pulses(1);
    chk("R7 resume after set", daddr, 16'h0100 + 2*STEP);
    @(negedge clk); xfer = 1; ld = 1; ld_addr = 16'h0300;
    @(negedge clk); xfer = 0; ld = 0;
    chk("R12 load priority", daddr, 16'h0300);
  endtask

  task automatic t_standby();
    chk("R1 pre-standby", rdata, 8'h90);
    @(negedge clk); standby = 1; wr = 1; wdata = 8'h3F;
    @(negedge clk); standby = 0; wr = 0;
    chk("R1 standby clear", rdata, 8'h00);
    chk("R1 standby chan_en", chan_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_arm();
    t_cancel();
    t_nmi();
    t_dst();
    t_standby();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule